// File: doc/BRIEF.md
# DIP4 Lock Detector

This block decides whether an incoming packet data path is in step with its sender by watching the outcome of the DIP4 parity check on each received control word. A strobe marks every control word whose parity has been checked, and a second input says whether that check passed. The detector keeps two run counters, one for consecutive passes and one for consecutive failures. Each counter is compared against a programmable threshold, which gives the block hysteresis between its two states.

Out of reset the detector is unlocked. In that state the outbound 2-bit flow-control status bus must carry continuous framing. Once the required run of passing results arrives, the detector locks, and the status bus switches to normal calendar transmission. A long enough run of failures sends it back to the unlocked state. Computing the parity and deskewing the lanes are done upstream and are not part of this block.

Top module: `dip4_lock_top`

## Requirements
- R1: After reset, `locked` is 0 and `statusMode` is 0, which selects framing.
- R2: While unlocked, `locked` rises on the clock edge that takes in the N-th consecutive passing result, where N is `lockThr`. It stays 0 after N-1 passing results.
- R3: While unlocked, a failing result clears the run of passing results, so a full run of N new passes is needed after it.
- R4: While locked, `locked` falls on the clock edge that takes in the M-th consecutive failing result, where M is `unlockThr`.
- R5: While locked, a passing result clears the run of failing results.
- R6: A threshold value of 0 behaves exactly like a threshold of 1.
- R7: `statusMode` is 1 (calendar) whenever `locked` is 1, and 0 (framing) whenever `locked` is 0.
- R8: Cycles with `dipValid` low have no effect, whatever the value of `dipGood`. They neither break a run nor extend it.
- R9: Both thresholds use their full 8-bit range. For example, a lock threshold of 255 needs 255 consecutive passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dipValid | input | 1 | Strobe: a DIP4 result is present this cycle |
| dipGood | input | 1 | DIP4 result: 1 = pass, 0 = fail |
| lockThr | input | THR_W | Consecutive passes needed to lock (0 treated as 1) |
| unlockThr | input | THR_W | Consecutive failures needed to unlock (0 treated as 1) |
| locked | output | 1 | Synchronization achieved |
| statusMode | output | 1 | Status bus source: 0 = framing, 1 = calendar |

## Verification
The bench builds the block with the default 8-bit threshold width and drives the thresholds at run time. Thresholds of 32 and 4 exercise the normal hysteresis and the run-clearing behaviour. A threshold of 0 checks the substitution of 1. A lock threshold of 255 reaches the top of the counter range. With 8-bit thresholds every run is at most 255 results long, so the counter limit is reached within a few hundred cycles.

// File: rtl/dip4_lock_pkg.sv
`timescale 1ns/1ps
package dip4_lock_pkg;
  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lockState_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic incGood;
    logic clrGood;
    logic incBad;
    logic clrBad;
  } cntCtrl_t;
endpackage

// File: rtl/dip4_lock_counters.sv
`timescale 1ns/1ps
module dip4_lock_counters
  import dip4_lock_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctrl,
  input  logic [THR_W-1:0] lockThr,
  input  logic [THR_W-1:0] unlockThr,
  output logic             goodAtLimit,
  output logic             badAtLimit
);
  localparam int EXT_W = THR_W + 1;

  logic [THR_W-1:0] goodCnt;
  logic [THR_W-1:0] badCnt;
  logic [EXT_W-1:0] effLock;
  logic [EXT_W-1:0] effUnlock;

  // A zero threshold is treated as one
  assign effLock   = (lockThr == '0)   ? EXT_W'(1) : {1'b0, lockThr};
  assign effUnlock = (unlockThr == '0) ? EXT_W'(1) : {1'b0, unlockThr};

  // The result arriving now would complete the run
  assign goodAtLimit = ({1'b0, goodCnt} + EXT_W'(1)) >= effLock;
  assign badAtLimit  = ({1'b0, badCnt} + EXT_W'(1)) >= effUnlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
    end else if (ctrl.clrGood) begin
      goodCnt <= '0;
    end else if (ctrl.incGood) begin
      goodCnt <= goodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badCnt <= '0;
    end else if (ctrl.clrBad) begin
      badCnt <= '0;
    end else if (ctrl.incBad) begin
      badCnt <= badCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dip4_lock_ctrl.sv
`timescale 1ns/1ps
module dip4_lock_ctrl
  import dip4_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dipValid,
  input  logic     dipGood,
  input  logic     goodAtLimit,
  input  logic     badAtLimit,
  output cntCtrl_t ctrl,
  output logic     locked,
  output logic     statusMode
);
  lockState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    if (dipValid) begin
      unique case (state)
        ST_UNLOCKED: begin
          if (!dipGood) begin
            ctrl.clrGood = 1'b1;
          end else if (goodAtLimit) begin
            stateNext    = ST_LOCKED;
            ctrl.clrGood = 1'b1;
            ctrl.clrBad  = 1'b1;
          end else begin
            ctrl.incGood = 1'b1;
          end
        end
        ST_LOCKED: begin
          if (dipGood) begin
            ctrl.clrBad = 1'b1;
          end else if (badAtLimit) begin
            stateNext    = ST_UNLOCKED;
            ctrl.clrGood = 1'b1;
            ctrl.clrBad  = 1'b1;
          end else begin
            ctrl.incBad = 1'b1;
          end
        end
        default: stateNext = ST_UNLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_UNLOCKED;
    end else begin
      state <= stateNext;
    end
  end

  assign locked     = (state == ST_LOCKED);
  assign statusMode = (state == ST_LOCKED);
endmodule

// File: rtl/dip4_lock_top.sv
`timescale 1ns/1ps
module dip4_lock_top
  import dip4_lock_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dipValid,
  input  logic             dipGood,
  input  logic [THR_W-1:0] lockThr,
  input  logic [THR_W-1:0] unlockThr,
  output logic             locked,
  output logic             statusMode
);
  cntCtrl_t cntCtrl;
  logic     goodAtLimit;
  logic     badAtLimit;

  dip4_lock_counters #(.THR_W(THR_W)) u_counters (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (cntCtrl),
    .lockThr    (lockThr),
    .unlockThr  (unlockThr),
    .goodAtLimit(goodAtLimit),
    .badAtLimit (badAtLimit)
  );

  dip4_lock_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dipValid   (dipValid),
    .dipGood    (dipGood),
    .goodAtLimit(goodAtLimit),
    .badAtLimit (badAtLimit),
    .ctrl       (cntCtrl),
    .locked     (locked),
    .statusMode (statusMode)
  );
endmodule

// File: rtl/dip4_lock_checker.sv
`timescale 1ns/1ps
module dip4_lock_checker #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dipValid,
  input logic             dipGood,
  input logic [THR_W-1:0] lockThr,
  input logic [THR_W-1:0] unlockThr,
  input logic             locked,
  input logic             statusMode
);
  assert_reset_unlocked_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!locked && !statusMode));

  assert_lock_needs_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(dipValid && dipGood));

  assert_unlock_needs_fail_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(dipValid && !dipGood));

  assert_zero_lock_thr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && dipValid && dipGood && (lockThr <= THR_W'(1))) |=> locked);

  assert_zero_unlock_thr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && dipValid && !dipGood && (unlockThr <= THR_W'(1))) |=> !locked);

  assert_mode_follows_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusMode == locked);

  assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    !dipValid |=> $stable(locked));
endmodule

bind dip4_lock_top dip4_lock_checker #(.THR_W(THR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .dipValid  (dipValid),
  .dipGood   (dipGood),
  .lockThr   (lockThr),
  .unlockThr (unlockThr),
  .locked    (locked),
  .statusMode(statusMode)
);

// File: tb/dip4_lock_top_tb.sv
`timescale 1ns/1ps
module dip4_lock_top_tb;
  localparam int THR_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             dipValid = 1'b0;
  logic             dipGood = 1'b0;
  logic [THR_W-1:0] lockThr = 8'd32;
  logic [THR_W-1:0] unlockThr = 8'd4;
  logic             locked;
  logic             statusMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dip4_lock_top #(.THR_W(THR_W)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .dipValid  (dipValid),
    .dipGood   (dipGood),
    .lockThr   (lockThr),
    .unlockThr (unlockThr),
    .locked    (locked),
    .statusMode(statusMode)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // n back-to-back results of one kind; the outputs are sampled at the next falling edge
  task automatic burst(input int n, input logic good);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dipValid = 1'b1;
      dipGood  = good;
    end
    @(negedge clk);
    dipValid = 1'b0;
    dipGood  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dipValid = 1'b0;
      dipGood  = i[0];
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    check("R1 locked after reset", locked, 1'b0);
    check("R1 framing after reset", statusMode, 1'b0);
  endtask

  task automatic t_lockUnlock();
    lockThr = 8'd32; unlockThr = 8'd4;
    doReset();
    burst(31, 1'b1);
    check("R2 unlocked after 31 passes", locked, 1'b0);
    check("R7 framing while unlocked", statusMode, 1'b0);
    burst(1, 1'b1);
    check("R2 locked after 32 passes", locked, 1'b1);
    check("R7 calendar while locked", statusMode, 1'b1);
    burst(3, 1'b0);
    check("R4 still locked after 3 fails", locked, 1'b1);
    burst(1, 1'b1);
    burst(3, 1'b0);
    check("R5 pass cleared fail run", locked, 1'b1);
    burst(1, 1'b0);
    check("R4 unlocked after 4 fails", locked, 1'b0);
    check("R7 framing after unlock", statusMode, 1'b0);
  endtask

  task automatic t_failBreaksRun();
    lockThr = 8'd32; unlockThr = 8'd4;
    doReset();
    burst(20, 1'b1);
    burst(1, 1'b0);
    burst(31, 1'b1);
    check("R3 fail cleared pass run", locked, 1'b0);
    burst(1, 1'b1);
    check("R3 locked after full new run", locked, 1'b1);
  endtask

  task automatic t_idleIgnored();
    lockThr = 8'd32; unlockThr = 8'd4;
    doReset();
    burst(16, 1'b1);
    idle(10);
    burst(15, 1'b1);
    idle(5);
    check("R8 idle cycles do not extend run", locked, 1'b0);
    burst(1, 1'b1);
    check("R8 idle cycles do not break run", locked, 1'b1);
    idle(40);
    check("R8 idle cycles do not unlock", locked, 1'b1);
    burst(3, 1'b0);
    idle(7);
    burst(1, 1'b0);
    check("R8 fail run spans idle gap", locked, 1'b0);
  endtask

  task automatic t_zeroThr();
    lockThr = 8'd0; unlockThr = 8'd0;
    doReset();
    burst(1, 1'b1);
    check("R6 zero lock threshold acts as one", locked, 1'b1);
    burst(1, 1'b0);
    check("R6 zero unlock threshold acts as one", locked, 1'b0);
  endtask

  task automatic t_maxThr();
    lockThr = 8'd255; unlockThr = 8'd4;
    doReset();
    burst(254, 1'b1);
    check("R9 unlocked after 254 passes", locked, 1'b0);
    burst(1, 1'b1);
    check("R9 locked after 255 passes", locked, 1'b1);
  endtask

  initial begin
    t_reset();
    t_lockUnlock();
    t_failBreaksRun();
    t_idleIgnored();
    t_zeroThr();
    t_maxThr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule